// File: doc/BRIEF.md
# Four-Port Store Arbiter

The block shares one store between four requesters. Ports 0 and 1 serve processor units and ports 2 and 3 serve I/O transfer controllers. Each port offers a request line, a 2-bit function code, a 26-bit real byte address, a 64-bit write data path and an 8-bit byte-enable mask. While idle, the arbiter picks one requesting port and registers it as the grant. It then drives a single synchronous store request built from that port's fields and holds the grant until the store acknowledges.

The I/O pair always takes precedence over the processor pair. Inside each pair a one-bit pointer remembers which member was served last, and a tie goes to the other member. The store acknowledge and read data go back to the granted port only. After every acknowledge the arbiter spends one idle cycle and arbitrates again in that cycle.

Top module: `store_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no request present, `st_valid` is 0 and `port_ack` is all zeros.
- R2: In an arbitration cycle where port 2 or port 3 requests, the grant goes to one of those two ports even if port 0 or port 1 also requests.
- R3: When both ports of a pair request in the same arbitration cycle, the port of that pair not granted most recently wins. The first tie after reset goes to the lower-numbered port (port 0, port 2).
- R4: A pair's last-served pointer changes only in a cycle where a port of that pair is granted. Grants to the other pair leave it unchanged.
- R5: Once granted, the grant and `st_valid` stay unchanged until `st_ack`. `st_addr` and `st_wdata` carry the granted port's address and data.
- R6: `st_valid` rises in the cycle after an idle cycle in which a request was present. After the cycle with `st_ack`, `st_valid` is 0 for exactly one cycle before a pending request is served.
- R7: `port_ack` is one-hot or zero. It is asserted only for the granted port and only in the cycle with `st_ack`. `port_rdata` carries `st_rdata` in that cycle.
- R8: Function codes: 0 read (`st_we`=0, `st_be`=0), 1 two-word write (`st_we`=1, `st_be`=8'hFF), 2 partial write (`st_we`=1, `st_be` = port mask, bit k enabling data bits 8k+7..8k), 3 reserved and handled as a read.
- R9: In an arbitration cycle with no request on ports 2 and 3, a requesting processor port is granted, however long it waited behind I/O traffic.
- R10: All 26 bits of the granted port's address reach `st_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_req | input | 4 | Request per port; bits 0,1 processor, bits 2,3 I/O |
| port_func | input | 8 | 2-bit function code per port, port i at bits 2i+1..2i |
| port_addr | input | 104 | 26-bit real byte address per port |
| port_wdata | input | 256 | 64-bit write data per port |
| port_be | input | 32 | 8-bit partial-write byte mask per port |
| port_ack | output | 4 | Transfer complete, one bit per port |
| port_rdata | output | 64 | Read data returned to the acknowledged port |
| st_valid | output | 1 | Store request active |
| st_we | output | 1 | Store request writes |
| st_addr | output | 26 | Store byte address |
| st_wdata | output | 64 | Store write data |
| st_be | output | 8 | Store byte enables |
| st_ack | input | 1 | Store completion strobe |
| st_rdata | input | 64 | Store read data, valid with st_ack |

## Verification
The bench raises every one of the fifteen non-empty request combinations at once, twice in a row so that the pointers start from different states. It compares the order of acknowledges against an order worked out from the pair priority and rotation rules. A design that let a processor port in ahead of waiting I/O, rotated a pointer on the other pair's grant, or started a tie from the wrong port would acknowledge out of order. The idle cycle after each acknowledge is checked explicitly, which catches an arbiter that re-grants in the acknowledge cycle or stalls an extra cycle. Single-byte, mixed and empty partial-write masks, full writes and the reserved code are each followed by a read-back from another port. A wrong byte-enable decode therefore shows up as corrupted or missing bytes in the store.

// File: rtl/store_arb_pkg.sv
package store_arb_pkg;
  localparam int unsigned NUM_PORTS = 4;
  localparam int unsigned PAIR_SIZE = 2;
  localparam int unsigned NUM_PAIRS = NUM_PORTS / PAIR_SIZE;
  localparam int unsigned FUNC_W    = 2;

  typedef enum logic [FUNC_W-1:0] {
    SF_READ    = 2'd0,
    SF_WRITE   = 2'd1,
    SF_PARTIAL = 2'd2,
    SF_RSVD    = 2'd3
  } sfunc_e;
endpackage

// File: rtl/store_arb_pair_rr.sv
// Two-member rotating selector with its own last-served pointer.
module store_arb_pair_rr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       take,
  output logic [1:0] pick
);
  logic last_q;
  logic last_d;

  always_comb begin
    unique case (req)
      2'b01:   pick = 2'b01;
      2'b10:   pick = 2'b10;
      2'b11:   pick = last_q ? 2'b01 : 2'b10;
      default: pick = 2'b00;
    endcase
  end

  always_comb begin
    last_d = last_q;
    if (take) last_d = pick[1];
  end

  // reset value 1 lets the lower member win the first tie
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (take) last_q <= last_d;
  end
endmodule

// File: rtl/store_arb_select.sv
// Pair-level fixed priority (highest pair index wins) over per-pair rotation.
module store_arb_select
  import store_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  input  logic                 arb_en,
  output logic [NUM_PORTS-1:0] win,
  output logic                 fire
);
  logic [NUM_PAIRS-1:0] pair_any;
  logic [NUM_PAIRS-1:0] pair_chosen;
  logic [NUM_PORTS-1:0] pair_pick;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign pair_any[g] = |req[g*PAIR_SIZE +: PAIR_SIZE];

    store_arb_pair_rr rr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req[g*PAIR_SIZE +: PAIR_SIZE]),
      .take (arb_en & pair_chosen[g]),
      .pick (pair_pick[g*PAIR_SIZE +: PAIR_SIZE])
    );

    assign win[g*PAIR_SIZE +: PAIR_SIZE] =
      pair_pick[g*PAIR_SIZE +: PAIR_SIZE] & {PAIR_SIZE{pair_chosen[g]}};
  end

  always_comb begin
    pair_chosen = '0;
    for (int g = 0; g < NUM_PAIRS; g++) begin
      if (pair_any[g]) pair_chosen = NUM_PAIRS'(1) << g;
    end
  end

  assign fire = arb_en & (|req);
endmodule

// File: rtl/store_arb_port_mux.sv
// AND-OR field selection for the granted port plus function decode.
module store_arb_port_mux
  import store_arb_pkg::*;
#(
  parameter  int unsigned ADDR_W = 26,
  parameter  int unsigned DATA_W = 64,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic [NUM_PORTS-1:0]        sel,
  input  logic [NUM_PORTS*FUNC_W-1:0] port_func,
  input  logic [NUM_PORTS*ADDR_W-1:0] port_addr,
  input  logic [NUM_PORTS*DATA_W-1:0] port_wdata,
  input  logic [NUM_PORTS*BE_W-1:0]   port_be,
  output logic                        m_we,
  output logic [ADDR_W-1:0]           m_addr,
  output logic [DATA_W-1:0]           m_wdata,
  output logic [BE_W-1:0]             m_be
);
  logic [FUNC_W-1:0] sel_func;
  logic [BE_W-1:0]   sel_be;

  always_comb begin
    sel_func = '0;
    sel_be   = '0;
    m_addr   = '0;
    m_wdata  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      sel_func = sel_func | ({FUNC_W{sel[i]}} & port_func[i*FUNC_W +: FUNC_W]);
      sel_be   = sel_be   | ({BE_W{sel[i]}}   & port_be[i*BE_W +: BE_W]);
      m_addr   = m_addr   | ({ADDR_W{sel[i]}} & port_addr[i*ADDR_W +: ADDR_W]);
      m_wdata  = m_wdata  | ({DATA_W{sel[i]}} & port_wdata[i*DATA_W +: DATA_W]);
    end
  end

  always_comb begin
    unique case (sfunc_e'(sel_func))
      SF_WRITE: begin
        m_we = 1'b1;
        m_be = '1;
      end
      SF_PARTIAL: begin
        m_we = 1'b1;
        m_be = sel_be;
      end
      default: begin
        m_we = 1'b0;
        m_be = '0;
      end
    endcase
  end
endmodule

// File: rtl/store_arbiter.sv
module store_arbiter
  import store_arb_pkg::*;
#(
  parameter  int unsigned ADDR_W = 26,
  parameter  int unsigned DATA_W = 64,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        port_req,
  input  logic [NUM_PORTS*FUNC_W-1:0] port_func,
  input  logic [NUM_PORTS*ADDR_W-1:0] port_addr,
  input  logic [NUM_PORTS*DATA_W-1:0] port_wdata,
  input  logic [NUM_PORTS*BE_W-1:0]   port_be,
  output logic [NUM_PORTS-1:0]        port_ack,
  output logic [DATA_W-1:0]           port_rdata,
  output logic                        st_valid,
  output logic                        st_we,
  output logic [ADDR_W-1:0]           st_addr,
  output logic [DATA_W-1:0]           st_wdata,
  output logic [BE_W-1:0]             st_be,
  input  logic                        st_ack,
  input  logic [DATA_W-1:0]           st_rdata
);
  logic                 busy_q, busy_d;
  logic [NUM_PORTS-1:0] grant_q, grant_d;
  logic                 state_en;
  logic [NUM_PORTS-1:0] win;
  logic                 fire;

  store_arb_select sel_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (port_req),
    .arb_en(~busy_q),
    .win   (win),
    .fire  (fire)
  );

  store_arb_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mux_i (
    .sel       (grant_q),
    .port_func (port_func),
    .port_addr (port_addr),
    .port_wdata(port_wdata),
    .port_be   (port_be),
    .m_we      (st_we),
    .m_addr    (st_addr),
    .m_wdata   (st_wdata),
    .m_be      (st_be)
  );

  always_comb begin
    busy_d   = busy_q;
    grant_d  = grant_q;
    state_en = 1'b0;
    if (!busy_q) begin
      if (fire) begin
        busy_d   = 1'b1;
        grant_d  = win;
        state_en = 1'b1;
      end
    end else if (st_ack) begin
      busy_d   = 1'b0;
      grant_d  = '0;
      state_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
    end else if (state_en) begin
      busy_q  <= busy_d;
      grant_q <= grant_d;
    end
  end

  assign st_valid   = busy_q;
  assign port_ack   = grant_q & {NUM_PORTS{st_ack}};
  assign port_rdata = st_rdata;
endmodule

// File: rtl/store_arbiter_chk.sv
module store_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] port_req,
  input logic [3:0] port_ack,
  input logic [3:0] grant_q,
  input logic       st_valid,
  input logic       st_ack
);
  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_ack));

  assert_ack_in_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_ack != 4'b0) |-> st_valid);

  assert_grant_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ack) |=> (st_valid && $stable(grant_q)));

  assert_idle_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st_ack |=> !st_valid);

  assert_io_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_valid) && $past(port_req[3] || port_req[2])) |-> (grant_q[3] || grant_q[2]));

  assert_cpu_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_valid) && $past(port_req[3:2] == 2'b00 && port_req[1:0] != 2'b00))
      |-> (grant_q[1] || grant_q[0]));
endmodule

bind store_arbiter store_arbiter_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .port_req(port_req),
  .port_ack(port_ack),
  .grant_q (grant_q),
  .st_valid(st_valid),
  .st_ack  (st_ack)
);

// File: tb/store_arbiter_tb.sv
module store_arbiter_tb_top;
  localparam int AW  = 26;
  localparam int DW  = 64;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0]    req;
  logic [7:0]    func;
  logic [4*AW-1:0] addr;
  logic [4*DW-1:0] wdata;
  logic [31:0]   be;
  logic [3:0]    port_ack;
  logic [DW-1:0] port_rdata;
  logic          st_valid, st_we, st_ack;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_wdata, st_rdata;
  logic [7:0]    st_be;

  logic [DW-1:0] mem  [16];
  logic [DW-1:0] expm [16];
  int            cnt;
  int            nchk = 0;
  int            nfail = 0;
  bit            exp_io_last, exp_cp_last;

  always #5 clk = ~clk;

  store_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .port_req(req), .port_func(func), .port_addr(addr),
    .port_wdata(wdata), .port_be(be), .port_ack(port_ack), .port_rdata(port_rdata),
    .st_valid(st_valid), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata),
    .st_be(st_be), .st_ack(st_ack), .st_rdata(st_rdata)
  );

  function automatic logic [DW-1:0] seed(int k);
    return {8'(k), 8'hC3, 16'(k * 37 + 5), 32'h5A5A0000 ^ 32'(k * 4099)};
  endfunction

  function automatic logic [AW-1:0] addr_of(int idx);
    return 26'h1500000 | 26'(idx << 3);
  endfunction

  // fixed-latency store model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ack   <= 1'b0;
      st_rdata <= '0;
      cnt      <= 0;
      for (int k = 0; k < 16; k++) mem[k] <= seed(k);
    end else if (st_ack) begin
      st_ack <= 1'b0;
    end else if (st_valid) begin
      if (cnt == LAT - 1) begin
        cnt      <= 0;
        st_ack   <= 1'b1;
        st_rdata <= mem[st_addr[6:3]];
        if (st_we)
          for (int b = 0; b < 8; b++)
            if (st_be[b]) mem[st_addr[6:3]][8*b +: 8] <= st_wdata[8*b +: 8];
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] ev);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, ev);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  function automatic int first_one(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  // all ports in pat request at once, each dropping after its ack
  task automatic run_pattern(input logic [3:0] pat);
    int ord[4];
    int n = 0;
    int k = 0;
    int cyc = 0;
    int idx[4];
    logic [3:0] rem = pat;
    while (rem != 4'b0) begin
      int base = (rem[3:2] != 2'b0) ? 2 : 0;
      logic [1:0] r = rem[base +: 2];
      bit l = (base == 2) ? exp_io_last : exp_cp_last;
      int w = (r == 2'b11) ? (l ? 0 : 1) : (r[1] ? 1 : 0);
      if (base == 2) exp_io_last = w[0]; else exp_cp_last = w[0];
      ord[n] = base + w;
      n++;
      rem[base + w] = 1'b0;
    end
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      idx[i] = (i * 5 + int'(pat)) & 15;
      func[i*2 +: 2]   = 2'd0;
      addr[i*AW +: AW] = addr_of(idx[i]);
      wdata[i*DW +: DW] = {32'hFFFF0000, 32'(i)};
      be[i*8 +: 8]     = 8'hFF;
    end
    req = pat;
    while (req != 4'b0 && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (port_ack != 4'b0) begin
        int g = first_one(port_ack);
        chk($onehot(port_ack), "R7 one-hot ack", DW'(port_ack), '0);
        chk(g == ord[k], (ord[k] < 2 && pat[3:2] != 2'b0) ? "R2 R9 order" : "R3 R4 order",
            DW'(g), DW'(ord[k]));
        chk(st_addr == addr_of(idx[ord[k]]), "R5 R10 address", DW'(st_addr), DW'(addr_of(idx[ord[k]])));
        chk(port_rdata == expm[idx[ord[k]]], "R7 read data", port_rdata, expm[idx[ord[k]]]);
        chk(!st_we && st_be == 8'h00, "R8 read decode", {st_we, st_be}, '0);
        if (g >= 0) req[g] = 1'b0;
        k++;
        if (req != 4'b0) begin
          @(negedge clk);
          chk(!st_valid && port_ack == 4'b0, "R6 idle cycle", {st_valid, port_ack}, '0);
          @(negedge clk);
          chk(st_valid, "R6 re-arbitration", DW'(st_valid), 1);
        end
      end
    end
    chk(k == n && cyc < 100, "R5 all served", DW'(k), DW'(n));
    req = 4'b0;
    @(negedge clk);
  endtask

  task automatic xfer(input int p, input logic [1:0] f, input int ix,
                      input logic [DW-1:0] wd, input logic [7:0] m, input string rq);
    int cyc = 0;
    logic [7:0] ebe;
    logic       ewe;
    @(negedge clk);
    func[p*2 +: 2]    = f;
    addr[p*AW +: AW]  = addr_of(ix);
    wdata[p*DW +: DW] = wd;
    be[p*8 +: 8]      = m;
    req[p]            = 1'b1;
    @(negedge clk);
    chk(st_valid, "R6 grant latency", DW'(st_valid), 1);
    while (port_ack == 4'b0 && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    ewe = (f == 2'd1 || f == 2'd2);
    ebe = (f == 2'd1) ? 8'hFF : (f == 2'd2) ? m : 8'h00;
    chk(port_ack == (4'b1 << p), {rq, " ack"}, DW'(port_ack), DW'(4'b1 << p));
    chk(st_we == ewe && st_be == ebe, {"R8 decode ", rq}, {st_we, st_be}, {ewe, ebe});
    chk(st_wdata == wd, "R5 write data", st_wdata, wd);
    if (!ewe) chk(port_rdata == expm[ix], {rq, " read back"}, port_rdata, expm[ix]);
    for (int b = 0; b < 8; b++)
      if (ebe[b] && ewe) expm[ix][8*b +: 8] = wd[8*b +: 8];
    req[p] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req = '0; func = '0; addr = '0; wdata = '0; be = '0;
    exp_io_last = 1'b1;
    exp_cp_last = 1'b1;
    for (int k = 0; k < 16; k++) expm[k] = seed(k);
    repeat (3) @(negedge clk);
    chk(!st_valid && port_ack == 4'b0, "R1 in reset", {st_valid, port_ack}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!st_valid && port_ack == 4'b0, "R1 after reset", {st_valid, port_ack}, '0);

    // exhaustive request combinations, two passes for differing pointer states
    for (int pass = 0; pass < 2; pass++)
      for (int pat = 1; pat < 16; pat++) run_pattern(4'(pat));

    // full writes, then read back from another port
    for (int p = 0; p < 4; p++) begin
      xfer(p, 2'd1, p + 8, seed(p + 40) ^ 64'h0F0F_F0F0_3C3C_C3C3, 8'h00, "R8 write");
      xfer((p + 1) % 4, 2'd0, p + 8, '0, 8'h00, "R8 read");
    end

    // partial writes over single-byte and mixed masks
    for (int m = 0; m < 12; m++) begin
      logic [7:0] mk;
      case (m)
        8:       mk = 8'h0F;
        9:       mk = 8'hF0;
        10:      mk = 8'h00;
        11:      mk = 8'hA5;
        default: mk = 8'(1 << m);
      endcase
      xfer(m % 4, 2'd2, m, 64'hDEAD_BEEF_0000_0000 | 64'(m * 257), mk, "R8 partial");
      xfer((m + 2) % 4, 2'd0, m, '0, 8'h00, "R8 partial read");
    end

    // reserved code handled as a read: store untouched
    xfer(1, 2'd3, 2, 64'hBAD0_BAD0_BAD0_BAD0, 8'hFF, "R8 reserved");
    xfer(3, 2'd0, 2, '0, 8'h00, "R8 reserved read");

    finish_run();
  end
endmodule